// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier with Range Flags

This block multiplies two 32-bit single-precision binary floating-point words in one combinational pass. The sign of the product is the exclusive-or of the operand signs. The biased exponents are added in a widened signed field and the bias is removed. The two 24-bit significands, each with its implicit leading one, are multiplied into a 48-bit unsigned product. That product is normalized by at most one right shift. The 23 fraction bits below the leading one are kept and the bits beneath them are dropped.

The result is checked against the normal exponent range before it is packed. If the exponent is too large, the output becomes a signed infinity and an overflow flag is raised. If it is too small, the output becomes a signed zero and an underflow flag is raised. An operand that is exactly zero (any sign) gives a signed zero with no flag. The block expects normal or zero operands. Subnormal operands, infinities and NaN inputs, and rounding modes other than truncation, are not part of its function. It sits on a datapath as pure logic, so its outputs follow its inputs with no latency.

Top module: `spfp_mul`

## Requirements
- R1: Word layout is sign in bit 31, biased exponent in bits 30:23 and fraction in bits 22:0. The result sign always equals op_a[31] XOR op_b[31], including for zero, infinity and flushed results.
- R2: The working exponent is Ea + Eb - 127, held wide enough that a sum above 255 is not wrapped. For example, 0x7F000000 x 0x3F800000 gives 0x7F000000.
- R3: Each significand is {1, fraction}, 24 bits wide. The two are multiplied unsigned into a 48-bit product, so 1.5 x 1.5 carries the full 2.25.
- R4: If product bit 47 is set, the exponent is raised by one and the fraction is product bits 46:24. Otherwise the fraction is product bits 45:23. Lower bits are truncated, never rounded.
- R5: For a non-zero, unflagged result, the exponent field lies in 1..254. The overflow and underflow flags are never high together.
- R6: If the final exponent is 255 or more, ovf_flag is 1 and product is the sign followed by 0x7F800000 (signed infinity). This includes a working exponent of 254 that normalization raises to 255.
- R7: If the final exponent is 0 or less, unf_flag is 1 and product is the sign followed by 31 zero bits. A working exponent of 0 that normalization raises to 1 is not an underflow.
- R8: If either operand has exponent 0 and fraction 0, product is a signed zero and both flags are 0.
- R9: 0x3F8CCCCD x 0x3F8CCCCD gives 0x3F9AE148, and 0x40200000 x 0x40980000 gives 0x413E0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand, single-precision word |
| op_b | input | 32 | Second operand, single-precision word |
| product | output | 32 | Packed product, saturated or flushed when a flag is set |
| ovf_flag | output | 1 | Final exponent exceeded 254; product is signed infinity |
| unf_flag | output | 1 | Final exponent fell to 0 or below; product is signed zero |

## Verification
The block has no state, so any fault shows up on the outputs for the same input word. Errors in the normalization decision appear in two ways: a fraction shifted one place out of position, and an exponent off by one. The exponent error is most visible at the two range edges, where a wrong increment turns a valid 254 into a false overflow, or fails to lift an intermediate 0 out of underflow. A wrapped exponent sum, or a zero operand that is not caught, gives a finite, wildly wrong magnitude for the same input. Constrained random operands across the whole exponent range, together with directed words at each boundary, make these errors visible on the first vector that hits them.

// File: rtl/fmul_pkg.sv
package fmul_pkg;
    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int SIG_W   = FRAC_W + 1;
    localparam int PROD_W  = 2 * SIG_W;
    localparam int WORD_W  = 1 + EXP_W + FRAC_W;
    localparam int IEXP_W  = EXP_W + 2;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_TOP = (1 << EXP_W) - 1;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  expo;
        logic [FRAC_W-1:0] frac;
    } fp_word_t;

    typedef struct packed {
        logic              sign;
        logic              is_zero;
        logic [EXP_W-1:0]  expo;
        logic [SIG_W-1:0]  sig;
    } fp_parts_t;

    typedef enum logic [1:0] {
        KIND_NORMAL,
        KIND_ZERO,
        KIND_OVER,
        KIND_UNDER
    } out_kind_t;

    function automatic fp_word_t make_special(input logic sgn, input logic as_inf);
        fp_word_t w;
        w.sign = sgn;
        w.expo = as_inf ? {EXP_W{1'b1}} : {EXP_W{1'b0}};
        w.frac = '0;
        return w;
    endfunction
endpackage

// File: rtl/fmul_unpack.sv
module fmul_unpack
    import fmul_pkg::*;
(
    input  logic [WORD_W-1:0] word_in,
    output fp_parts_t         parts
);
    fp_word_t w;

    always_comb begin
        w             = fp_word_t'(word_in);
        parts.sign    = w.sign;
        parts.expo    = w.expo;
        parts.is_zero = (w.expo == '0) && (w.frac == '0);
        parts.sig     = {1'b1, w.frac};
    end
endmodule

// File: rtl/fmul_sigmul.sv
module fmul_sigmul
    import fmul_pkg::*;
(
    input  logic [SIG_W-1:0]  sig_a,
    input  logic [SIG_W-1:0]  sig_b,
    output logic [PROD_W-1:0] prod
);
    logic [PROD_W-1:0] partial [SIG_W];

    for (genvar i = 0; i < SIG_W; i++) begin : g_pp
        assign partial[i] = sig_b[i] ? (PROD_W'(sig_a) << i) : '0;
    end

    always_comb begin
        prod = '0;
        for (int k = 0; k < SIG_W; k++) begin
            prod = prod + partial[k];
        end
    end
endmodule

// File: rtl/fmul_normpack.sv
module fmul_normpack
    import fmul_pkg::*;
(
    input  logic              res_sign,
    input  logic              any_zero,
    input  logic [EXP_W-1:0]  expo_a,
    input  logic [EXP_W-1:0]  expo_b,
    input  logic [PROD_W-1:0] prod,
    output logic [WORD_W-1:0] word_out,
    output logic              ovf,
    output logic              unf
);
    logic signed [IEXP_W-1:0] exp_mid;
    logic signed [IEXP_W-1:0] exp_fin;
    logic                     top_set;
    logic [FRAC_W-1:0]        frac_sel;
    out_kind_t                kind;
    fp_word_t                 res;

    always_comb begin
        exp_mid  = $signed({2'b00, expo_a}) + $signed({2'b00, expo_b})
                 - $signed(IEXP_W'(BIAS));
        top_set  = prod[PROD_W-1];
        exp_fin  = exp_mid + (top_set ? $signed(IEXP_W'(1)) : $signed(IEXP_W'(0)));
        frac_sel = top_set ? prod[PROD_W-2 -: FRAC_W] : prod[PROD_W-3 -: FRAC_W];

        if (any_zero)
            kind = KIND_ZERO;
        else if (exp_fin >= $signed(IEXP_W'(EXP_TOP)))
            kind = KIND_OVER;
        else if (exp_fin <= $signed(IEXP_W'(0)))
            kind = KIND_UNDER;
        else
            kind = KIND_NORMAL;

        res = '0;
        case (kind)
            KIND_OVER:   res = make_special(res_sign, 1'b1);
            KIND_ZERO,
            KIND_UNDER:  res = make_special(res_sign, 1'b0);
            default: begin
                res.sign = res_sign;
                res.expo = exp_fin[EXP_W-1:0];
                res.frac = frac_sel;
            end
        endcase

        word_out = res;
        ovf      = (kind == KIND_OVER);
        unf      = (kind == KIND_UNDER);
    end
endmodule

// File: rtl/spfp_mul.sv
module spfp_mul
    import fmul_pkg::*;
(
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output logic [WORD_W-1:0] product,
    output logic              ovf_flag,
    output logic              unf_flag
);
    localparam int N_OPS = 2;

    logic [WORD_W-1:0] ops [N_OPS];
    fp_parts_t         parts [N_OPS];
    logic [PROD_W-1:0] sig_prod;

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    for (genvar j = 0; j < N_OPS; j++) begin : g_unpack
        fmul_unpack u_unpack (
            .word_in (ops[j]),
            .parts   (parts[j])
        );
    end

    fmul_sigmul u_sigmul (
        .sig_a (parts[0].sig),
        .sig_b (parts[1].sig),
        .prod  (sig_prod)
    );

    fmul_normpack u_normpack (
        .res_sign (parts[0].sign ^ parts[1].sign),
        .any_zero (parts[0].is_zero | parts[1].is_zero),
        .expo_a   (parts[0].expo),
        .expo_b   (parts[1].expo),
        .prod     (sig_prod),
        .word_out (product),
        .ovf      (ovf_flag),
        .unf      (unf_flag)
    );
endmodule

// File: rtl/spfp_mul_chk.sv
module spfp_mul_chk
    import fmul_pkg::*;
(
    input logic [WORD_W-1:0] op_a,
    input logic [WORD_W-1:0] op_b,
    input logic [WORD_W-1:0] product,
    input logic              ovf_flag,
    input logic              unf_flag
);
    logic zero_op;
    logic known;

    always_comb begin
        known   = !$isunknown({op_a, op_b, product, ovf_flag, unf_flag});
        zero_op = (op_a[WORD_W-2:0] == '0) || (op_b[WORD_W-2:0] == '0);

        if (known) begin
            a_r1_sign_xor: assert (product[WORD_W-1] == (op_a[WORD_W-1] ^ op_b[WORD_W-1]))
                else $error("R1 sign mismatch");
            a_r5_flags_exclusive: assert (!(ovf_flag && unf_flag))
                else $error("R5 both flags high");
            a_r5_normal_range: assert (zero_op || ovf_flag || unf_flag
                    || (product[WORD_W-2 -: EXP_W] != '0
                        && product[WORD_W-2 -: EXP_W] != {EXP_W{1'b1}}))
                else $error("R5 exponent out of normal range");
            a_r6_overflow_inf: assert (!ovf_flag
                    || (product[WORD_W-2 -: EXP_W] == {EXP_W{1'b1}}
                        && product[FRAC_W-1:0] == '0))
                else $error("R6 overflow not infinity");
            a_r7_underflow_zero: assert (!unf_flag || product[WORD_W-2:0] == '0)
                else $error("R7 underflow not zero");
            a_r8_zero_operand: assert (!zero_op
                    || (product[WORD_W-2:0] == '0 && !ovf_flag && !unf_flag))
                else $error("R8 zero operand mishandled");
        end
    end
endmodule

bind spfp_mul spfp_mul_chk u_chk (
    .op_a     (op_a),
    .op_b     (op_b),
    .product  (product),
    .ovf_flag (ovf_flag),
    .unf_flag (unf_flag)
);

// File: tb/spfp_mul_test.sv
module spfp_mul_test;
    logic        clk = 1'b0;
    logic [31:0] op_a, op_b, product;
    logic        ovf_flag, unf_flag;
    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    spfp_mul uut (
        .op_a     (op_a),
        .op_b     (op_b),
        .product  (product),
        .ovf_flag (ovf_flag),
        .unf_flag (unf_flag)
    );

    function automatic logic [33:0] model(input logic [31:0] a, input logic [31:0] b);
        logic         s;
        int           e;
        longint       ma, mb, p;
        logic [22:0]  f;
        s = a[31] ^ b[31];
        if (a[30:0] == 0 || b[30:0] == 0) return {2'b00, s, 31'h0};
        ma = longint'({1'b1, a[22:0]});
        mb = longint'({1'b1, b[22:0]});
        p  = ma * mb;
        e  = int'(a[30:23]) + int'(b[30:23]) - 127;
        if (p >= (longint'(1) << 47)) begin
            e = e + 1;
            f = 23'(p >> 24);
        end else begin
            f = 23'(p >> 23);
        end
        if (e >= 255) return {2'b10, s, 8'hFF, 23'h0};
        if (e <= 0)   return {2'b01, s, 31'h0};
        return {2'b00, s, 8'(e), f};
    endfunction

    task automatic apply(input logic [31:0] a, input logic [31:0] b, input string req);
        logic [33:0] exp_v;
        @(posedge clk);
        op_a = a;
        op_b = b;
        @(negedge clk);
        exp_v = model(a, b);
        n_checks++;
        if ({ovf_flag, unf_flag, product} !== exp_v) begin
            n_errors++;
            $display("FAIL %s a=%h b=%h actual ovf=%b unf=%b p=%h expected ovf=%b unf=%b p=%h",
                     req, a, b, ovf_flag, unf_flag, product, exp_v[33], exp_v[32], exp_v[31:0]);
        end
    endtask

    task automatic apply_fixed(input logic [31:0] a, input logic [31:0] b,
                               input logic [33:0] want, input string req);
        @(posedge clk);
        op_a = a;
        op_b = b;
        @(negedge clk);
        n_checks++;
        if ({ovf_flag, unf_flag, product} !== want) begin
            n_errors++;
            $display("FAIL %s a=%h b=%h actual %b%b %h expected %b%b %h", req, a, b,
                     ovf_flag, unf_flag, product, want[33], want[32], want[31:0]);
        end
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] ra, rb;
        void'($urandom(32'd1234));
        op_a = 32'h3F800000;
        op_b = 32'h3F800000;
        @(negedge clk);
        n_checks++;
        if ({ovf_flag, unf_flag, product} !== {2'b00, 32'h3F800000}) begin
            n_errors++;
            $display("FAIL R4 initial 1*1 actual %h expected 3f800000", product);
        end

        // R9 known products
        apply_fixed(32'h3F8CCCCD, 32'h3F8CCCCD, {2'b00, 32'h3F9AE148}, "R9");
        apply_fixed(32'h40200000, 32'h40980000, {2'b00, 32'h413E0000}, "R9");
        // R1 sign
        apply_fixed(32'hC0000000, 32'h40400000, {2'b00, 32'hC0C00000}, "R1");
        apply_fixed(32'hC0000000, 32'hC0400000, {2'b00, 32'h40C00000}, "R1");
        // R2 wide exponent sum, top of range kept
        apply_fixed(32'h7F000000, 32'h3F800000, {2'b00, 32'h7F000000}, "R2");
        // R3 / R4 1.5*1.5 = 2.25 shifts
        apply_fixed(32'h3FC00000, 32'h3FC00000, {2'b00, 32'h40100000}, "R3_R4");
        // R6 plain overflow and 254 raised to 255
        apply_fixed(32'h7F000000, 32'h40000000, {2'b10, 32'h7F800000}, "R6");
        apply_fixed(32'hFF7FFFFF, 32'h3FC00000, {2'b10, 32'hFF800000}, "R6");
        // R7 underflow at exactly 0, negative, and recovered case
        apply_fixed(32'h00800000, 32'hBF000000, {2'b01, 32'h80000000}, "R7");
        apply_fixed(32'h00800000, 32'h00800000, {2'b01, 32'h00000000}, "R7");
        apply_fixed(32'h00C00000, 32'h3F400000, {2'b00, 32'h00900000}, "R7");
        // R8 zero operands
        apply_fixed(32'h80000000, 32'h40000000, {2'b00, 32'h80000000}, "R8");
        apply_fixed(32'h7F7FFFFF, 32'h00000000, {2'b00, 32'h00000000}, "R8");
        // R5 smallest normal result
        apply_fixed(32'h00800000, 32'h3F800000, {2'b00, 32'h00800000}, "R5");

        for (int i = 0; i < 400; i++) begin
            ra = $urandom;
            rb = $urandom;
            ra[30:23] = 8'(1 + ($urandom % 254));
            rb[30:23] = 8'(1 + ($urandom % 254));
            if (($urandom % 20) == 0) ra[30:0] = '0;
            apply(ra, rb, "R4_R5_R6_R7_random");
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule